// File: doc/BRIEF.md
# Serial GFSK Uplink Frame Builder

This block assembles a complete variable-length uplink frame for a 50 kbit/s GFSK transmitter and emits it one bit at a time. The payload is first written into an internal byte buffer. A start strobe then launches a frame with the requested length. The serial stream carries, in this order: a run of alternating-pattern preamble bytes, a fixed three-byte network sync word, one length byte, the payload bytes, and a two-byte CRC.

The length byte, the payload and the CRC are scrambled with a PN9 whitening sequence so that the line stays DC-balanced. The preamble and the sync word are sent as they are. Every bit is presented on a serial data output together with a one-cycle valid strobe, paced by a divider set to the system clock over the bit rate. A one-cycle done pulse marks the end of the frame. Modulation, pulse shaping and RF control are handled downstream.

Top module: `gfsk_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is running, `bit_vld_o`, `done_o` and `bit_o` are 0.
- R2: `start_i` is accepted only while idle. At acceptance `len_i` is captured. A start strobe or a new `len_i` value during a frame has no effect on the bits, the strobe timing or the done pulse of that frame.
- R3: Let DIV = CLK_HZ / BIT_HZ. The first `bit_vld_o` pulse comes DIV cycles after the clock edge that accepts the start. Each later pulse comes exactly DIV cycles after the one before it. Each pulse lasts one cycle, and `bit_o` is valid during the pulse.
- R4: The frame opens with PRE_BYTES bytes of 0xAA (default 5). These bytes are not whitened. Every byte of the frame goes out most significant bit first.
- R5: Three unwhitened sync bytes follow the preamble, in the order 0xC1, 0x94, 0xC1.
- R6: After the sync word comes the length byte, equal to the captured length. It is followed by that many payload bytes, read from buffer addresses 0 up to length-1. A length of 0 sends no payload bytes.
- R7: The length byte, the payload and both CRC bytes are each XORed with a whitening mask. A 9-bit state is seeded to 0x1FF at frame start. Each mask is the state's low 8 bits, with mask bit i applied to byte bit i. After each use, the state takes 8 steps, where one step is: new bit 8 = bit 0 XOR bit 5, and all other bits move down by one place.
- R8: The CRC is computed MSB first with polynomial 0x1021, starting from 0x1D0F, over the unwhitened length byte and payload. It is inverted and sent as the high byte followed by the low byte.
- R9: `done_o` is high for exactly one cycle: the cycle after the strobe that carries the last CRC bit.
- R10: When `wr_en_i` is high at a clock edge, `wr_data_i` is stored at buffer address `wr_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Payload buffer write enable |
| wr_addr_i | input | LEN_W | Payload buffer write address |
| wr_data_i | input | 8 | Payload byte to store |
| len_i | input | LEN_W | Payload length, captured at start |
| start_i | input | 1 | Frame start strobe |
| bit_o | output | 1 | Serial frame bit |
| bit_vld_o | output | 1 | One-cycle strobe marking a valid `bit_o` |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The properties assume that DIV is at least 2. This lets back-to-back strobes be ruled out and lets the gap between strobes be counted. They also assume that all inputs are synchronous to `clk`. The buffer must not be rewritten while a frame is being sent, because payload bytes are fetched only when they are loaded into the shift register. The stimulus therefore performs every buffer write between frames, and keeps DIV at 4 so that frames of full length stay short. Mid-frame start pulses and changes of `len_i` are applied on purpose, since the block must ignore them.

// File: rtl/gfsk_frame_pkg.sv
package gfsk_frame_pkg;

    localparam logic [7:0]  PRE_PAT    = 8'hAA;
    localparam int unsigned SYNC_BYTES = 3;
    localparam logic [15:0] CRC_SEED   = 16'h1D0F;
    localparam logic [15:0] CRC_POLY   = 16'h1021;
    localparam logic [8:0]  PN9_SEED   = 9'h1FF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_LEN,
        ST_PAY,
        ST_CRC
    } phase_e;

    // Network sync word, first byte on air at index 0.
    function automatic logic [7:0] sync_byte(input int unsigned idx);
        case (idx)
            0:       return 8'hC1;
            1:       return 8'h94;
            default: return 8'hC1;
        endcase
    endfunction

    // One byte through the CRC register, data MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c;
        for (int i = 7; i >= 0; i--) begin
            if (x[15] ^ d[i]) x = {x[14:0], 1'b0} ^ CRC_POLY;
            else              x = {x[14:0], 1'b0};
        end
        return x;
    endfunction

    // Eight steps of the PN9 generator (x^9 + x^5 + 1).
    function automatic logic [8:0] pn9_adv8(input logic [8:0] s);
        logic [8:0] x;
        x = s;
        for (int i = 0; i < 8; i++) x = {x[0] ^ x[5], x[8:1]};
        return x;
    endfunction

endpackage

// File: rtl/gfsk_bit_tick.sv
module gfsk_bit_tick #(
    parameter int unsigned DIV = 640
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !en_i)                cnt_d = '0;
        else if (cnt_q == CW'(DIV - 1))    cnt_d = '0;
        else                               cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && !clr_i && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/gfsk_pn9_white.sv
module gfsk_pn9_white
    import gfsk_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seed_i,
    input  logic       adv_i,
    output logic [7:0] mask_o
);
    logic [8:0] st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (seed_i)     st_d = PN9_SEED;
        else if (adv_i) st_d = pn9_adv8(st_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PN9_SEED;
        else        st_q <= st_d;
    end

    assign mask_o = st_q[7:0];
endmodule

// File: rtl/gfsk_crc16.sv
module gfsk_crc16
    import gfsk_frame_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [7:0]  data_i,
    output logic [15:0] crc_o
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (init_i)     crc_d = CRC_SEED;
        else if (upd_i) crc_d = crc16_byte(crc_q, data_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= CRC_SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/gfsk_frame_tx.sv
module gfsk_frame_tx
    import gfsk_frame_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 32_000_000,
    parameter int unsigned BIT_HZ    = 50_000,
    parameter int unsigned PRE_BYTES = 5,
    parameter int unsigned LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [LEN_W-1:0] wr_addr_i,
    input  logic [7:0]       wr_data_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             start_i,
    output logic             bit_o,
    output logic             bit_vld_o,
    output logic             done_o
);
    localparam int unsigned DIV   = CLK_HZ / BIT_HZ;
    localparam int unsigned DEPTH = 1 << LEN_W;

    typedef struct packed {
        phase_e           phase;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] idx;
        logic [2:0]       bitn;
        logic [7:0]       sr;
        logic             done;
    } regs_t;

    regs_t r_d, r_q;

    logic [7:0]       mem_q [DEPTH];
    logic [LEN_W-1:0] rd_idx;
    logic [7:0]       mem_rd;
    logic             tick;
    logic             start_acc;
    logic             wh_adv;
    logic [7:0]       wh_mask;
    logic             crc_upd;
    logic [7:0]       crc_data;
    logic [15:0]      crc_val;

    // Payload buffer
    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    end

    assign rd_idx    = (r_q.phase == ST_PAY) ? r_q.idx + LEN_W'(1) : '0;
    assign mem_rd    = mem_q[rd_idx];
    assign start_acc = (r_q.phase == ST_IDLE) && start_i;

    gfsk_bit_tick #(.DIV(DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.phase != ST_IDLE),
        .clr_i  (start_acc),
        .tick_o (tick)
    );

    gfsk_pn9_white white_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed_i (start_acc),
        .adv_i  (wh_adv),
        .mask_o (wh_mask)
    );

    gfsk_crc16 crc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (start_acc),
        .upd_i  (crc_upd),
        .data_i (crc_data),
        .crc_o  (crc_val)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        wh_adv   = 1'b0;
        crc_upd  = 1'b0;
        crc_data = '0;
        if (r_q.phase == ST_IDLE) begin
            if (start_i) begin
                r_d.phase = ST_PRE;
                r_d.len   = len_i;
                r_d.idx   = '0;
                r_d.bitn  = '0;
                r_d.sr    = PRE_PAT;
            end
        end else if (tick) begin
            if (r_q.bitn != 3'd7) begin
                r_d.sr   = {r_q.sr[6:0], 1'b0};
                r_d.bitn = r_q.bitn + 3'd1;
            end else begin
                r_d.bitn = '0;
                r_d.idx  = r_q.idx + LEN_W'(1);
                case (r_q.phase)
                    ST_PRE: begin
                        if (r_q.idx == LEN_W'(PRE_BYTES - 1)) begin
                            r_d.phase = ST_SYNC;
                            r_d.idx   = '0;
                            r_d.sr    = sync_byte(0);
                        end else begin
                            r_d.sr = PRE_PAT;
                        end
                    end
                    ST_SYNC: begin
                        if (r_q.idx == LEN_W'(SYNC_BYTES - 1)) begin
                            r_d.phase = ST_LEN;
                            r_d.idx   = '0;
                            r_d.sr    = 8'(r_q.len) ^ wh_mask;
                            wh_adv    = 1'b1;
                            crc_upd   = 1'b1;
                            crc_data  = 8'(r_q.len);
                        end else begin
                            r_d.sr = sync_byte(int'(r_q.idx) + 1);
                        end
                    end
                    ST_LEN: begin
                        r_d.idx = '0;
                        wh_adv  = 1'b1;
                        if (r_q.len == '0) begin
                            r_d.phase = ST_CRC;
                            r_d.sr    = ~crc_val[15:8] ^ wh_mask;
                        end else begin
                            r_d.phase = ST_PAY;
                            r_d.sr    = mem_rd ^ wh_mask;
                            crc_upd   = 1'b1;
                            crc_data  = mem_rd;
                        end
                    end
                    ST_PAY: begin
                        wh_adv = 1'b1;
                        if (r_q.idx == r_q.len - LEN_W'(1)) begin
                            r_d.phase = ST_CRC;
                            r_d.idx   = '0;
                            r_d.sr    = ~crc_val[15:8] ^ wh_mask;
                        end else begin
                            r_d.sr   = mem_rd ^ wh_mask;
                            crc_upd  = 1'b1;
                            crc_data = mem_rd;
                        end
                    end
                    default: begin
                        if (r_q.idx == '0) begin
                            r_d.sr = ~crc_val[7:0] ^ wh_mask;
                            wh_adv = 1'b1;
                        end else begin
                            r_d.phase = ST_IDLE;
                            r_d.idx   = '0;
                            r_d.sr    = '0;
                            r_d.done  = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.phase <= ST_IDLE;
            r_q.len   <= '0;
            r_q.idx   <= '0;
            r_q.bitn  <= '0;
            r_q.sr    <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_o     = r_q.sr[7];
    assign bit_vld_o = tick;
    assign done_o    = r_q.done;
endmodule

// File: rtl/gfsk_frame_tx_chk.sv
module gfsk_frame_tx_chk #(
    parameter int unsigned CLK_HZ = 32_000_000,
    parameter int unsigned BIT_HZ = 50_000,
    parameter int unsigned LEN_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             bit_vld_o,
    input logic             done_o,
    input logic             busy_i,
    input logic [LEN_W-1:0] len_q_i
);
    localparam int unsigned DIV = CLK_HZ / BIT_HZ;
    localparam int unsigned GW  = $clog2(DIV) + 2;

    logic [GW-1:0] gap_q;

    // Cycles since the last strobe or since the start was accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                              gap_q <= '0;
        else if (bit_vld_o || (!busy_i && start_i)) gap_q <= '0;
        else if (gap_q != '1)                    gap_q <= gap_q + GW'(1);
    end

    a_r1_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |-> !bit_vld_o);

    a_r2_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(len_q_i));

    a_r3_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> (gap_q == GW'(DIV - 1)));

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |=> !bit_vld_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(bit_vld_o) && !busy_i));
endmodule

bind gfsk_frame_tx gfsk_frame_tx_chk #(
    .CLK_HZ (CLK_HZ),
    .BIT_HZ (BIT_HZ),
    .LEN_W  (LEN_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .bit_vld_o (bit_vld_o),
    .done_o    (done_o),
    .busy_i    (r_q.phase != gfsk_frame_pkg::ST_IDLE),
    .len_q_i   (r_q.len)
);

// File: tb/gfsk_frame_tx_tb_top.sv
module gfsk_frame_tx_tb_top;
    localparam int unsigned CLK_HZ = 200_000_000;
    localparam int unsigned BIT_HZ = 50_000_000;
    localparam int unsigned DIV    = CLK_HZ / BIT_HZ;
    localparam int unsigned PRE    = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] len_i = '0;
    logic       start_i = 1'b0;
    logic       bit_o, bit_vld_o, done_o;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;
    logic [7:0] shadow [256];
    bit    exp_bits[$];
    string exp_tag[$];

    always #2.5ns clk = ~clk;

    gfsk_frame_tx #(
        .CLK_HZ    (CLK_HZ),
        .BIT_HZ    (BIT_HZ),
        .PRE_BYTES (PRE),
        .LEN_W     (8)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .len_i     (len_i),
        .start_i   (start_i),
        .bit_o     (bit_o),
        .bit_vld_o (bit_vld_o),
        .done_o    (done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic void push_byte(input logic [7:0] b, input string tag);
        for (int i = 7; i >= 0; i--) begin
            exp_bits.push_back(b[i]);
            exp_tag.push_back(tag);
        end
    endfunction

    function automatic int crc_step(input int c, input int b);
        int x;
        x = c;
        for (int i = 7; i >= 0; i--) begin
            int fb;
            fb = ((x >> 15) ^ (b >> i)) & 1;
            x = (x << 1) & 16'hFFFF;
            if (fb != 0) x = x ^ 16'h1021;
        end
        return x;
    endfunction

    function automatic int pn9_next(input int s);
        int x;
        x = s;
        for (int i = 0; i < 8; i++) begin
            int fb;
            fb = (x ^ (x >> 5)) & 1;
            x = (x >> 1) | (fb << 8);
        end
        return x;
    endfunction

    // Expected bit stream of one frame, built from the requirements.
    function automatic void build(input int len);
        int s, crc, inv;
        exp_bits.delete();
        exp_tag.delete();
        s = 9'h1FF;
        crc = 16'h1D0F;
        for (int i = 0; i < PRE; i++) push_byte(8'hAA, "R4");
        push_byte(8'hC1, "R5");
        push_byte(8'h94, "R5");
        push_byte(8'hC1, "R5");
        push_byte(8'(len ^ (s & 8'hFF)), "R6 R7");
        crc = crc_step(crc, len);
        s = pn9_next(s);
        for (int i = 0; i < len; i++) begin
            push_byte(8'(int'(shadow[i]) ^ (s & 8'hFF)), "R6 R7 R10");
            crc = crc_step(crc, int'(shadow[i]));
            s = pn9_next(s);
        end
        inv = (~crc) & 16'hFFFF;
        push_byte(8'((inv >> 8) ^ (s & 8'hFF)), "R8 R7");
        s = pn9_next(s);
        push_byte(8'((inv & 8'hFF) ^ (s & 8'hFF)), "R8 R7");
    endfunction

    task automatic wr(input int addr, input int data);
        // R10: buffer writes happen only between frames
        wr_en_i   = 1'b1;
        wr_addr_i = 8'(addr);
        wr_data_i = 8'(data);
        shadow[addr] = 8'(data);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic run_frame(input int len, input bit poke);
        int n;
        build(len);
        n = exp_bits.size();
        start_i = 1'b1;
        len_i   = 8'(len);
        for (int t = 1; t <= n * int'(DIV) + 3; t++) begin
            bit exp_v;
            string extra;
            @(negedge clk);
            extra = poke ? " R2" : "";
            exp_v = (t % DIV == 0) && (t / DIV <= n);
            chk(bit_vld_o == exp_v, {"R3", extra}, $sformatf("strobe t=%0d", t), bit_vld_o, exp_v);
            if (exp_v) begin
                int k;
                k = t / DIV - 1;
                chk(bit_o == exp_bits[k], {exp_tag[k], extra}, $sformatf("len %0d bit %0d", len, k),
                    bit_o, exp_bits[k]);
            end
            chk(done_o == (t == n * int'(DIV) + 1), {"R9", extra}, $sformatf("done t=%0d", t),
                done_o, (t == n * int'(DIV) + 1));
            if (t > n * int'(DIV) + 1)
                chk(bit_o == 1'b0, "R1", "idle bit after frame", bit_o, 0);
            start_i = 1'b0;
            if (poke && (t == 10 * DIV + 1 || t == 30 * DIV + 2)) begin
                // R2: start and a different length during the frame
                start_i = 1'b1;
                len_i   = 8'(len ^ 8'h5A);
            end
        end
        start_i = 1'b0;
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        chk(bit_vld_o == 1'b0, "R1", "strobe in reset", bit_vld_o, 0);
        chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        rst_n = 1'b1;
        // R10: fill the whole buffer, including address 0 and the top address
        for (int i = 0; i < 256; i++) wr(i, (i * 37 + 11) & 8'hFF);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(bit_vld_o == 1'b0, "R1", "idle strobe", bit_vld_o, 0);
            chk(bit_o == 1'b0, "R1", "idle bit", bit_o, 0);
            chk(done_o == 1'b0, "R1", "idle done", done_o, 0);
        end
        run_frame(0, 1'b0);     // R6: empty payload
        run_frame(1, 1'b0);
        run_frame(6, 1'b1);     // R2: ignored start and length mid-frame
        @(negedge clk);
        wr(0, 8'h00);
        wr(1, 8'hFF);
        wr(2, 8'hA5);
        run_frame(3, 1'b0);
        run_frame(255, 1'b0);   // longest payload
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule